// File: doc/BRIEF.md
# Raster Sync and Data-Enable Timing Generator

This block drives a display panel's raster timing. Running on the pixel clock, it keeps a horizontal and a vertical counter. From these it produces the horizontal sync, vertical sync and data-enable strobes, the current pixel coordinates, and a one-cycle line-position interrupt. Software does not program the geometry as segment lengths. It programs cumulative boundaries: the sync width minus one, then that value plus the back porch, then that plus the active size, then that plus the front porch. Each horizontal/vertical pair shares one 32-bit word.

All timing words and the interrupt line number are written into a pending set, which the raster does not see. A reload request copies the pending set into the active set. The copy happens either on the next clock or at the first cycle after the last active line has ended. The request bits clear by themselves once the copy is done. A control word, which takes effect at once, holds the run enable, the polarity of each strobe, and a flag that a clocking block outside uses to invert the pixel clock.

Top module: `raster_timing_gen`

## Requirements
- R1: Write addresses 0, 1, 2 and 3 hold the pending sync, back-porch, active and total words. Each word packs the horizontal value in bits 27:16 and the vertical value in bits 10:0. Address 6 holds the pending interrupt line number in bits 10:0.
- R2: While enabled, the horizontal count steps from 0 up to the active total-width value and back to 0. The vertical count advances on each horizontal wrap and wraps after the active total-height value. While disabled, both counts are held at 0.
- R3: The internal horizontal sync is active while the horizontal count is at or below the active horizontal sync value. The vertical sync behaves the same way on the vertical count. Both are inactive while disabled.
- R4: Data enable is active only where the count is above the back-porch value and at or below the active value, in both dimensions at once.
- R5: The control word sits at address 4. Bit 0 enables the generator. Bits 31, 30 and 29 make horizontal sync, vertical sync and data enable active-high (when clear, the strobe is active-low). Bit 28 appears on `pclk_inv`. The control word takes effect on the next clock.
- R6: Writes to the pending set change no output until a reload copies them.
- R7: Writing address 5 with bit 0 set requests an immediate reload. The copy happens on the following clock edge, and the request bits then read as cleared.
- R8: Writing address 5 with bit 1 set requests a blanking reload. While the generator is enabled, the copy happens at the edge that ends the last active line, so the next line already runs on the new values. The request bits then clear.
- R9: `line_irq` is high for exactly the cycle at column 0 of the line equal to the active interrupt line number, and only while enabled.
- R10: If a reload leaves a count above its new total, that count wraps to 0 at its next step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync, programmable polarity |
| vsync | output | 1 | Vertical sync, programmable polarity |
| de | output | 1 | Data enable, programmable polarity |
| pclk_inv | output | 1 | Pixel clock inversion flag |
| line_irq | output | 1 | Line-position interrupt pulse |
| pix_x | output | 12 | Horizontal count |
| pix_y | output | 11 | Vertical count |

## Verification
Two events can fall in the same cycle: the blanking reload and the line interrupt. When the interrupt line is set to the active height plus one, the pulse lands on the very cycle the freshly copied set first governs. The bench provokes this by staging a new geometry with a blanking reload while the line number equals the last active line plus one. A cycle-accurate behavioural model then judges every output on every clock, and per-frame counts of data-enable cycles and interrupt pulses are checked against the values the geometry implies.

// File: rtl/raster_timing_gen.sv
module raster_timing_gen #(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [31:0]   wr_data,
  output logic          hsync,
  output logic          vsync,
  output logic          de,
  output logic          pclk_inv,
  output logic          line_irq,
  output logic [HW-1:0] pix_x,
  output logic [VW-1:0] pix_y
);
  localparam int HLSB = 16;
  localparam logic [AW-1:0] A_CTRL = AW'(4);
  localparam logic [AW-1:0] A_RLD  = AW'(5);
  localparam logic [AW-1:0] A_LINE = AW'(6);

  logic [HW-1:0] ph [4];
  logic [HW-1:0] ah [4];
  logic [VW-1:0] pv [4];
  logic [VW-1:0] av [4];
  logic [VW-1:0] plin, alin;
  logic en, hs_hi, vs_hi, de_hi, pinv;
  logic rld_imm, rld_vbr;
  logic [HW-1:0] hcnt;
  logic [VW-1:0] vcnt;

  logic h_wrap, v_wrap, at_blank, copy;
  assign h_wrap   = hcnt >= ah[3];
  assign v_wrap   = vcnt >= av[3];
  assign at_blank = en && h_wrap && (vcnt == av[2]);
  assign copy     = rld_imm || (rld_vbr && at_blank);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        ph[i] <= '0; ah[i] <= '0; pv[i] <= '0; av[i] <= '0;
      end
      plin <= '0; alin <= '0;
      en <= 1'b0; hs_hi <= 1'b0; vs_hi <= 1'b0; de_hi <= 1'b0; pinv <= 1'b0;
      rld_imm <= 1'b0; rld_vbr <= 1'b0;
      hcnt <= '0; vcnt <= '0;
    end else begin
      if (copy) begin
        for (int i = 0; i < 4; i++) begin
          ah[i] <= ph[i];
          av[i] <= pv[i];
        end
        alin    <= plin;
        rld_imm <= 1'b0;
        rld_vbr <= 1'b0;
      end
      if (wr_en) begin
        if (wr_addr < A_CTRL) begin
          ph[wr_addr[1:0]] <= wr_data[HLSB +: HW];
          pv[wr_addr[1:0]] <= wr_data[0 +: VW];
        end else if (wr_addr == A_CTRL) begin
          en    <= wr_data[0];
          pinv  <= wr_data[28];
          de_hi <= wr_data[29];
          vs_hi <= wr_data[30];
          hs_hi <= wr_data[31];
        end else if (wr_addr == A_RLD) begin
          if (wr_data[0]) rld_imm <= 1'b1;
          if (wr_data[1]) rld_vbr <= 1'b1;
        end else if (wr_addr == A_LINE) begin
          plin <= wr_data[0 +: VW];
        end
      end
      if (!en) begin
        hcnt <= '0;
        vcnt <= '0;
      end else if (h_wrap) begin
        hcnt <= '0;
        vcnt <= v_wrap ? '0 : vcnt + 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  logic hs_on, vs_on, de_on;
  assign hs_on = en && (hcnt <= ah[0]);
  assign vs_on = en && (vcnt <= av[0]);
  assign de_on = en && (hcnt > ah[1]) && (hcnt <= ah[2])
                    && (vcnt > av[1]) && (vcnt <= av[2]);

  assign hsync    = hs_hi ? hs_on : !hs_on;
  assign vsync    = vs_hi ? vs_on : !vs_on;
  assign de       = de_hi ? de_on : !de_on;
  assign pclk_inv = pinv;
  assign line_irq = en && (hcnt == '0) && (vcnt == alin);
  assign pix_x    = hcnt;
  assign pix_y    = vcnt;
endmodule

module raster_timing_chk #(
  parameter int HW = 12,
  parameter int VW = 11,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic [AW-1:0] wr_addr,
  input logic [31:0]   wr_data,
  input logic          en,
  input logic          de_hi,
  input logic          de,
  input logic          line_irq,
  input logic [HW-1:0] pix_x,
  input logic [VW-1:0] pix_y,
  input logic [HW-1:0] tot_h,
  input logic [HW-1:0] bp_h,
  input logic [VW-1:0] bp_v,
  input logic [VW-1:0] alin,
  input logic          rld_imm,
  input logic          rld_vbr
);
  AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !en && !(wr_en && wr_addr == AW'(4)) |=> pix_x == '0 && pix_y == '0); // R2

  AST_X_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    en && pix_x < tot_h && !(wr_en && wr_addr == AW'(4)) |=> pix_x == $past(pix_x) + 1'b1); // R2

  AST_DE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    de == de_hi |-> en && pix_x > bp_h && pix_y > bp_v); // R4

  AST_IRQ_SPOT: assert property (@(posedge clk) disable iff (!rst_n)
    line_irq |-> pix_x == '0 && pix_y == alin); // R9

  AST_IMM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    rld_imm && !(wr_en && wr_addr == AW'(5)) |=> !rld_imm && !rld_vbr); // R7

  AST_ACTIVE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !rld_imm && !rld_vbr |=> $stable(tot_h) && $stable(alin)); // R6
endmodule

bind raster_timing_gen raster_timing_chk #(.HW(HW), .VW(VW), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .en(en), .de_hi(de_hi), .de(de), .line_irq(line_irq),
  .pix_x(pix_x), .pix_y(pix_y), .tot_h(ah[3]), .bp_h(ah[1]), .bp_v(av[1]),
  .alin(alin), .rld_imm(rld_imm), .rld_vbr(rld_vbr)
);

// File: tb/sim_raster_timing_gen.sv
`timescale 1ns/1ps
module sim_raster_timing_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic hsync, vsync, de, pclk_inv, line_irq;
  logic [11:0] pix_x;
  logic [10:0] pix_y;

  always #4 clk = ~clk;

  raster_timing_gen u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync(hsync), .vsync(vsync), .de(de), .pclk_inv(pclk_inv),
    .line_irq(line_irq), .pix_x(pix_x), .pix_y(pix_y)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int ph[4], pv[4], ah[4], av[4];
  int plin, alin, h, v;
  bit en, hhi, vhi, dhi, pinv, q_imm, q_vbr;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin ph[i] = 0; pv[i] = 0; ah[i] = 0; av[i] = 0; end
      plin = 0; alin = 0; h = 0; v = 0;
      en = 0; hhi = 0; vhi = 0; dhi = 0; pinv = 0; q_imm = 0; q_vbr = 0;
    end else begin
      bit last, cp;
      last = en && (h >= ah[3]) && (v == av[2]);
      cp = q_imm || (q_vbr && last);
      if (!en) begin h = 0; v = 0; end
      else if (h >= ah[3]) begin h = 0; v = (v >= av[3]) ? 0 : v + 1; end
      else h = h + 1;
      if (cp) begin
        for (int i = 0; i < 4; i++) begin ah[i] = ph[i]; av[i] = pv[i]; end
        alin = plin; q_imm = 0; q_vbr = 0;
      end
      if (wr_en) begin
        case (wr_addr)
          0, 1, 2, 3: begin ph[wr_addr] = (wr_data >> 16) & 'hFFF; pv[wr_addr] = wr_data & 'h7FF; end
          4: begin en = wr_data[0]; pinv = wr_data[28]; dhi = wr_data[29];
                   vhi = wr_data[30]; hhi = wr_data[31]; end
          5: begin if (wr_data[0]) q_imm = 1; if (wr_data[1]) q_vbr = 1; end
          6: plin = wr_data & 'h7FF;
          default: ;
        endcase
      end
    end
    #2;
    if (!done) begin
      bit hs, vs, dn;
      hs = en && (h <= ah[0]);
      vs = en && (v <= av[0]);
      dn = en && h > ah[1] && h <= ah[2] && v > av[1] && v <= av[2];
      chk("R2 pix_x", pix_x, h);
      chk("R2 pix_y", pix_y, v);
      chk("R3 hsync", hsync, hhi ? hs : !hs);
      chk("R3 vsync", vsync, vhi ? vs : !vs);
      chk("R4 de", de, dhi ? dn : !dn);
      chk("R5 pclk_inv", pclk_inv, pinv);
      chk("R9 line_irq", line_irq, en && h == 0 && v == alin);
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a[2:0]; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_frame(input int n, output int nde, output int nirq);
    nde = 0; nirq = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (de) nde++;
      if (line_irq) nirq++;
    end
  endtask

  initial begin
    #(8 * 200000);
    $display("FAIL watchdog expired");
    errors++;
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int nde, nirq;
    repeat (3) @(negedge clk);
    chk("R2 reset pix_x", pix_x, 0);
    chk("R5 reset de low-active idle", de, 1);
    rst_n = 1'b1;
    // R1 geometry: h sync1 bp3 act7 tot9, v sync0 bp1 act4 tot5
    wr(0, (1 << 16) | 0);
    wr(1, (3 << 16) | 1);
    wr(2, (7 << 16) | 4);
    wr(3, (9 << 16) | 5);
    wr(6, 5);
    repeat (5) @(negedge clk);
    chk("R6 no effect before reload", pix_x, 0);
    wr(5, 1);                       // R7 immediate
    wr(4, 32'hA000_0001);
    count_frame(60, nde, nirq);
    chk("R4 de cycles per frame", nde, 12);
    chk("R9 irq per frame", nirq, 1);
    wr(2, (8 << 16) | 4);           // pending only
    count_frame(60, nde, nirq);
    chk("R6 pending write ignored", nde, 12);
    wr(3, (11 << 16) | 5);
    wr(5, 2);                       // R8 blanking reload, irq line = act+1
    repeat (80) @(negedge clk);
    count_frame(72, nde, nirq);
    chk("R8 de after blanking reload", nde, 15);
    chk("R8 irq with reload coincident", nirq, 1);
    wr(4, 32'h1000_0001);           // R5 all active-low, inverted clock
    repeat (100) @(negedge clk);
    wr(4, 32'hE000_0001);
    while (pix_x != 10) @(negedge clk);
    wr(3, (4 << 16) | 2);           // R10 shrink total below count
    wr(5, 1);
    repeat (60) @(negedge clk);
    wr(5, 3);                       // R7 both bits, immediate wins
    repeat (20) @(negedge clk);
    wr(4, 0);                       // R2 disable
    repeat (20) @(negedge clk);
    chk("R2 held when off", pix_y, 0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule